// File: doc/BRIEF.md
# SPI Engine Host Register Bank

This block is the software-facing front of a command-driven SPI engine. A host reaches it over a plain 32-bit register bus with byte offsets. Through that bus it can hold the engine in reset, queue command words and outgoing serial data, drain incoming serial data, read the fill state of each queue, and handle interrupts. The serial execution itself lives elsewhere. This block only hands commands and transmit words to the engine and takes receive words back from it.

Three queues sit inside the block: a command queue and a transmit queue that the bus fills and the engine drains, and a receive queue that the engine fills and the bus drains. Every engine-side data path is a valid/ready stream. An outgoing stream holds `valid` and keeps its data unchanged until the engine raises `ready`. The incoming stream is accepted on any cycle where both `valid` and `ready` are high, and `ready` drops while the receive queue is full.

Interrupts come from watermark comparisons on the three queues and from a sync event that the engine signals together with an ID. Bus reads are registered: the value for a read issued in one cycle appears on `bus_rdata` after the next rising clock edge.

Top module: `spieng_regbank`

## Requirements
- R1: After reset: `engine_rst` is 1, the enable and pending registers read 0, `irq` is 0, and the sync ID reads 0. The command room and transmit room read their depths (8 by default), and the receive level reads 0.
- R2: A write to offset 0x40 sets `engine_rst` to bit 0 of the written word. A read of 0x40 returns that bit.
- R3: A write to 0xE0 queues the low CMD_W bits as a command. Commands leave in write order on the command stream. While `cmd_valid` is high and `cmd_ready` is low, `cmd_data` holds steady. Offset 0xD0 reads depth minus occupancy. A write while the queue is full is dropped.
- R4: A write to 0xE4 queues a transmit word. It leaves in order on the transmit stream with the same hold rule. Offset 0xD4 reads the free entries.
- R5: `sdi_ready` is low exactly while the receive queue holds its depth in words, and offered words are not taken then. Offset 0xD8 reads the word count. A read of 0xE8 returns and removes the oldest word. A read of 0xE8 on an empty queue returns 0 and changes nothing.
- R6: A read of 0xEC returns the oldest receive word (0 when empty) without removing it.
- R7: Offset 0x88 (source) gives the raw status. Bit 0 is set when the command occupancy is at most CMD_AE (2). Bit 1 is set when the transmit occupancy is at most SDO_AE (2). Bit 2 is set when the receive occupancy is at least SDI_AF (6). Bit 3 is the sticky sync flag.
- R8: Offset 0x80 is a 4-bit enable. Bits 0–2 of offset 0x84 (pending) equal source AND enable. Writing ones to those pending bits leaves them unchanged.
- R9: A one-cycle `sync_valid` stores `sync_id` for readback at 0xC0 and sets the sync flag. Pending bit 3 is the flag AND enable bit 3. Writing a 1 to pending bit 3 (for example 0xFF) clears the flag. Writing 0 there leaves it set.
- R10: `irq` is high exactly when any pending bit is set.
- R11: Read data for any offset appears on `bus_rdata` one cycle after the read. Offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| engine_rst | output | 1 | Reset hold toward the engine |
| irq | output | 1 | Interrupt request |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready |
| cmd_data | output | CMD_W | Command word |
| sdo_valid | output | 1 | Transmit stream valid |
| sdo_ready | input | 1 | Transmit stream ready |
| sdo_data | output | DATA_W | Transmit word |
| sdi_valid | input | 1 | Receive stream valid |
| sdi_ready | output | 1 | Receive stream ready |
| sdi_data | input | DATA_W | Receive word |
| sync_valid | input | 1 | Sync event pulse |
| sync_id | input | ID_W | ID carried by the sync event |

## Verification
The command queue is first filled past its depth while the engine holds `ready` low. This separates dropping extra writes from overwriting, and shows that the head word stays put under back-pressure. The receive queue is driven through peek, pop, fill-to-full and an empty pop. That sequence separates a destructive read from a non-destructive one and shows what happens at both ends of the queue. The interrupt checks use several settings of the enable register against the same source state. Sync events are raised with the sync interrupt both enabled and masked. Clears are tried with 0 and with 1 written to the pending bit, so a sticky flag can be told apart from a level bit.

// File: rtl/spieng_pkg.sv
package spieng_pkg;
  localparam logic [7:0] OFS_RST   = 8'h40;
  localparam logic [7:0] OFS_IEN   = 8'h80;
  localparam logic [7:0] OFS_IPEND = 8'h84;
  localparam logic [7:0] OFS_ISRC  = 8'h88;
  localparam logic [7:0] OFS_SYNC  = 8'hC0;
  localparam logic [7:0] OFS_CROOM = 8'hD0;
  localparam logic [7:0] OFS_DROOM = 8'hD4;
  localparam logic [7:0] OFS_RLVL  = 8'hD8;
  localparam logic [7:0] OFS_CPUSH = 8'hE0;
  localparam logic [7:0] OFS_DPUSH = 8'hE4;
  localparam logic [7:0] OFS_RPOP  = 8'hE8;
  localparam logic [7:0] OFS_RPEEK = 8'hEC;

  localparam int NIRQ     = 4;
  localparam int IRQ_CMD  = 0;
  localparam int IRQ_SDO  = 1;
  localparam int IRQ_SDI  = 2;
  localparam int IRQ_SYNC = 3;
endpackage

// File: rtl/spieng_qfifo.sv
module spieng_qfifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] fill
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign in_ready  = (fill != CW'(DEPTH));
  assign out_valid = (fill != '0);
  assign out_data  = mem[rp];
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_valid && out_ready;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= in_data;
  end
endmodule

// File: rtl/spieng_irqctl.sv
module spieng_irqctl
  import spieng_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      lvl_src,
  input  logic            sync_evt,
  input  logic            en_wr,
  input  logic [NIRQ-1:0] en_wdata,
  input  logic            clr_wr,
  input  logic [NIRQ-1:0] clr_wdata,
  output logic [NIRQ-1:0] src,
  output logic [NIRQ-1:0] en,
  output logic [NIRQ-1:0] pend,
  output logic            irq
);
  logic sync_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= '0;
      sync_flag <= 1'b0;
    end else begin
      if (en_wr) en <= en_wdata;
      if (sync_evt)                         sync_flag <= 1'b1;
      else if (clr_wr && clr_wdata[IRQ_SYNC]) sync_flag <= 1'b0;
    end
  end

  assign src  = {sync_flag, lvl_src};
  assign pend = src & en;
  assign irq  = |pend;
endmodule

// File: rtl/spieng_regbank.sv
module spieng_regbank
  import spieng_pkg::*;
#(
  parameter int CMD_W     = 16,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 8,
  parameter int CMD_DEPTH = 8,
  parameter int SDO_DEPTH = 8,
  parameter int SDI_DEPTH = 8,
  parameter int CMD_AE    = 2,
  parameter int SDO_AE    = 2,
  parameter int SDI_AF    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              engine_rst,
  output logic              irq,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_data,
  output logic              sdo_valid,
  input  logic              sdo_ready,
  output logic [DATA_W-1:0] sdo_data,
  input  logic              sdi_valid,
  output logic              sdi_ready,
  input  logic [DATA_W-1:0] sdi_data,
  input  logic              sync_valid,
  input  logic [ID_W-1:0]   sync_id
);
  localparam int CCW = $clog2(CMD_DEPTH + 1);
  localparam int DCW = $clog2(SDO_DEPTH + 1);
  localparam int RCW = $clog2(SDI_DEPTH + 1);

  logic [CCW-1:0]  cmd_fill;
  logic [DCW-1:0]  sdo_fill;
  logic [RCW-1:0]  sdi_fill;
  logic            cmd_in_rdy, sdo_in_rdy;
  logic            sdi_has;
  logic [DATA_W-1:0] sdi_head;
  logic            wr_cmd, wr_sdo, rd_pop, is_pop_or_peek;
  logic [ID_W-1:0] sync_id_q;
  logic [NIRQ-1:0] int_src, int_en, int_pend;
  logic [31:0]     rd_mux;

  assign wr_cmd = bus_wr && (bus_addr == OFS_CPUSH) && cmd_in_rdy;
  assign wr_sdo = bus_wr && (bus_addr == OFS_DPUSH) && sdo_in_rdy;
  assign rd_pop = bus_rd && (bus_addr == OFS_RPOP) && sdi_has;
  assign is_pop_or_peek = (bus_addr == OFS_RPOP) || (bus_addr == OFS_RPEEK);

  spieng_qfifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(wr_cmd), .in_ready(cmd_in_rdy), .in_data(bus_wdata[CMD_W-1:0]),
    .out_valid(cmd_valid), .out_ready(cmd_ready), .out_data(cmd_data),
    .fill(cmd_fill)
  );

  spieng_qfifo #(.W(DATA_W), .DEPTH(SDO_DEPTH)) u_sdoq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(wr_sdo), .in_ready(sdo_in_rdy), .in_data(bus_wdata[DATA_W-1:0]),
    .out_valid(sdo_valid), .out_ready(sdo_ready), .out_data(sdo_data),
    .fill(sdo_fill)
  );

  spieng_qfifo #(.W(DATA_W), .DEPTH(SDI_DEPTH)) u_sdiq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(sdi_valid), .in_ready(sdi_ready), .in_data(sdi_data),
    .out_valid(sdi_has), .out_ready(rd_pop), .out_data(sdi_head),
    .fill(sdi_fill)
  );

  spieng_irqctl u_irq (
    .clk(clk), .rst_n(rst_n),
    .lvl_src({ (32'(sdi_fill) >= 32'(SDI_AF)),
               (32'(sdo_fill) <= 32'(SDO_AE)),
               (32'(cmd_fill) <= 32'(CMD_AE)) }),
    .sync_evt(sync_valid),
    .en_wr(bus_wr && (bus_addr == OFS_IEN)),
    .en_wdata(bus_wdata[NIRQ-1:0]),
    .clr_wr(bus_wr && (bus_addr == OFS_IPEND)),
    .clr_wdata(bus_wdata[NIRQ-1:0]),
    .src(int_src), .en(int_en), .pend(int_pend), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      engine_rst <= 1'b1;
      sync_id_q  <= '0;
    end else begin
      if (bus_wr && (bus_addr == OFS_RST)) engine_rst <= bus_wdata[0];
      if (sync_valid) sync_id_q <= sync_id;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (is_pop_or_peek) begin
      if (sdi_has) rd_mux = 32'(sdi_head);
    end else begin
      case (bus_addr)
        OFS_RST:   rd_mux = {31'd0, engine_rst};
        OFS_IEN:   rd_mux = 32'(int_en);
        OFS_IPEND: rd_mux = 32'(int_pend);
        OFS_ISRC:  rd_mux = 32'(int_src);
        OFS_SYNC:  rd_mux = 32'(sync_id_q);
        OFS_CROOM: rd_mux = 32'(CMD_DEPTH) - 32'(cmd_fill);
        OFS_DROOM: rd_mux = 32'(SDO_DEPTH) - 32'(sdo_fill);
        OFS_RLVL:  rd_mux = 32'(sdi_fill);
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/spieng_regbank_chk.sv
module spieng_regbank_chk #(
  parameter int CMD_W     = 16,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 8,
  parameter int SDI_DEPTH = 8,
  localparam int RCW      = $clog2(SDI_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              engine_rst,
  input logic              irq,
  input logic [3:0]        int_en,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [CMD_W-1:0]  cmd_data,
  input logic              sdo_valid,
  input logic              sdo_ready,
  input logic [DATA_W-1:0] sdo_data,
  input logic              sdi_ready,
  input logic [RCW-1:0]    sdi_fill,
  input logic              sync_valid,
  input logic [ID_W-1:0]   sync_id,
  input logic [ID_W-1:0]   sync_id_q
);
  // R2
  rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h40) |=> (engine_rst == $past(bus_wdata[0])));

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_valid && !sdo_ready) |=> (sdo_valid && $stable(sdo_data)));

  // R5
  sdi_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdi_ready |-> (32'(sdi_fill) == 32'(SDI_DEPTH)));

  // R9
  sync_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |=> (sync_id_q == $past(sync_id)));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_en != 4'd0));
endmodule

bind spieng_regbank spieng_regbank_chk #(
  .CMD_W(CMD_W), .DATA_W(DATA_W), .ID_W(ID_W), .SDI_DEPTH(SDI_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .engine_rst(engine_rst), .irq(irq), .int_en(int_en),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
  .sdo_valid(sdo_valid), .sdo_ready(sdo_ready), .sdo_data(sdo_data),
  .sdi_ready(sdi_ready), .sdi_fill(sdi_fill), .sync_valid(sync_valid),
  .sync_id(sync_id), .sync_id_q(sync_id_q)
);

// File: tb/sim_spieng_regbank.sv
`timescale 1ns/1ps
module sim_spieng_regbank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        engine_rst, irq;
  logic        cmd_valid, cmd_ready = 0;
  logic [15:0] cmd_data;
  logic        sdo_valid, sdo_ready = 0;
  logic [31:0] sdo_data;
  logic        sdi_valid = 0, sdi_ready;
  logic [31:0] sdi_data = 0;
  logic        sync_valid = 0;
  logic [7:0]  sync_id = 0;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  spieng_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .engine_rst(engine_rst), .irq(irq),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .sdo_valid(sdo_valid), .sdo_ready(sdo_ready), .sdo_data(sdo_data),
    .sdi_valid(sdi_valid), .sdi_ready(sdi_ready), .sdi_data(sdi_data),
    .sync_valid(sync_valid), .sync_id(sync_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    chk("R1 engine_rst", engine_rst, 1);
    chk("R1 irq", irq, 0);
    rdchk("R1 rst reg", 8'h40, 1);
    rdchk("R1 enable", 8'h80, 0);
    rdchk("R1 pending", 8'h84, 0);
    rdchk("R7 source at reset", 8'h88, 32'h3);
    rdchk("R1 sync id", 8'hC0, 0);
    rdchk("R1 cmd room", 8'hD0, 8);
    rdchk("R1 sdo room", 8'hD4, 8);
    rdchk("R1 sdi level", 8'hD8, 0);
  endtask

  task automatic t_rst_ctl;
    wr(8'h40, 0);
    chk("R2 release", engine_rst, 0);
    rdchk("R2 readback 0", 8'h40, 0);
    wr(8'h40, 32'h3);
    chk("R2 hold", engine_rst, 1);
    wr(8'h40, 32'h2);
    chk("R2 bit0 only", engine_rst, 0);
  endtask

  task automatic t_cmd;
    for (int i = 0; i < 10; i++) wr(8'hE0, 32'h100 + i);
    rdchk("R3 room full", 8'hD0, 0);
    rdchk("R7 cmd not almost empty", 8'h88, 32'h2);
    chk("R3 head held", cmd_data, 16'h100);
    @(negedge clk); cmd_ready = 1;
    for (int i = 0; i < 8; i++) begin
      chk("R3 valid", cmd_valid, 1);
      chk("R3 order", cmd_data, 16'h100 + i);
      @(negedge clk);
    end
    cmd_ready = 0;
    chk("R3 overflow dropped", cmd_valid, 0);
    rdchk("R3 room empty", 8'hD0, 8);
  endtask

  task automatic t_sdo;
    wr(8'hE4, 32'hDEAD0001);
    wr(8'hE4, 32'hDEAD0002);
    wr(8'hE4, 32'hDEAD0003);
    rdchk("R4 room", 8'hD4, 5);
    rdchk("R7 sdo above mark", 8'h88, 32'h1);
    @(negedge clk); sdo_ready = 1;
    chk("R4 head", sdo_data, 32'hDEAD0001);
    @(negedge clk); sdo_ready = 0;
    chk("R4 next", sdo_data, 32'hDEAD0002);
    rdchk("R7 sdo at mark", 8'h88, 32'h3);
  endtask

  task automatic sdi_push(input logic [31:0] d);
    @(negedge clk); sdi_valid = 1; sdi_data = d;
    @(negedge clk); sdi_valid = 0;
  endtask

  task automatic t_sdi;
    for (int i = 0; i < 6; i++) sdi_push(32'hA0 + i);
    rdchk("R5 level 6", 8'hD8, 6);
    rdchk("R7 sdi almost full", 8'h88, 32'h7);
    rdchk("R6 peek", 8'hEC, 32'hA0);
    rdchk("R6 peek keeps level", 8'hD8, 6);
    rdchk("R5 pop first", 8'hE8, 32'hA0);
    rdchk("R5 pop second", 8'hE8, 32'hA1);
    rdchk("R7 sdi below mark", 8'h88, 32'h3);
    for (int i = 0; i < 4; i++) sdi_push(32'hB0 + i);
    chk("R5 ready low full", sdi_ready, 0);
    sdi_push(32'hCC);
    rdchk("R5 level full", 8'hD8, 8);
    for (int i = 2; i < 6; i++) rdchk("R5 pop A", 8'hE8, 32'hA0 + i);
    for (int i = 0; i < 4; i++) rdchk("R5 pop B", 8'hE8, 32'hB0 + i);
    rdchk("R5 empty pop", 8'hE8, 0);
    rdchk("R6 empty peek", 8'hEC, 0);
    rdchk("R5 level empty", 8'hD8, 0);
  endtask

  task automatic t_irq;
    wr(8'h80, 32'h7);
    rdchk("R8 pending", 8'h84, 32'h3);
    chk("R10 irq on", irq, 1);
    wr(8'h84, 32'h7);
    rdchk("R8 w1 to level bits", 8'h84, 32'h3);
    wr(8'h80, 32'h2);
    rdchk("R8 partial mask", 8'h84, 32'h2);
    wr(8'h80, 32'h0);
    rdchk("R8 masked", 8'h84, 0);
    chk("R10 irq off", irq, 0);
  endtask

  task automatic sync_pulse(input logic [7:0] id);
    @(negedge clk); sync_valid = 1; sync_id = id;
    @(negedge clk); sync_valid = 0;
  endtask

  task automatic t_sync;
    wr(8'h80, 32'h8);
    sync_pulse(8'h5A);
    rdchk("R9 id", 8'hC0, 32'h5A);
    rdchk("R9 pending", 8'h84, 32'h8);
    chk("R10 irq sync", irq, 1);
    wr(8'h84, 32'h0);
    rdchk("R9 write 0 keeps", 8'h84, 32'h8);
    wr(8'h84, 32'hFF);
    rdchk("R9 cleared", 8'h84, 0);
    rdchk("R7 sync source clear", 8'h88, 32'h3);
    chk("R10 irq cleared", irq, 0);
    wr(8'h80, 32'h0);
    sync_pulse(8'h33);
    rdchk("R7 sync source set", 8'h88, 32'hB);
    chk("R10 masked sync", irq, 0);
    rdchk("R9 second id", 8'hC0, 32'h33);
    wr(8'h80, 32'h8);
    rdchk("R9 enable late", 8'h84, 32'h8);
    chk("R10 irq late", irq, 1);
  endtask

  task automatic t_unmapped;
    rdchk("R11 unmapped 44", 8'h44, 0);
    rdchk("R11 unmapped FC", 8'hFC, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_rst_ctl;
    t_cmd;
    t_sdo;
    t_sdi;
    t_irq;
    t_sync;
    t_unmapped;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule